// File: doc/BRIEF.md
# Little-Endian Load/Store Byte-Lane Unit

This block sits between a 32-bit integer core and a data memory organised as full words with per-byte write enables. On the store side it receives the low bits of the effective address, the source register value and the access size. It produces one write enable per byte lane and places the write data on the lanes that the address selects. On the load side it receives the word read from memory with the same low address bits, a size and a signedness select. It picks out the addressed byte, halfword or word and widens it to the full register width with either sign or zero fill. Byte order is little-endian, so the lowest address maps to the least significant byte.

The effective-address adder is not part of this block. An access whose offset does not suit its size is flagged and otherwise suppressed: a flagged store drives no enables, and a flagged load returns zero. The store path and the load path are separate and registered. Each result appears on the clock edge after its request.

Top module: `lsu_byte_lane`

## Requirements
- R1: While `rst` is high, every output is zero at the following clock edge.
- R2: A byte store (size code 2'b00) at offset k drives `mem_be` = 1<<k and puts `st_data[7:0]` on lane k (bits 8k+7..8k). All other lanes are zero.
- R3: A halfword store (size code 2'b01) at an even offset k drives `mem_be` = 2'b11<<k and puts `st_data[15:0]` on lanes k and k+1, low byte on lane k. All other lanes are zero.
- R4: A word store (size code 2'b10) at offset 0 drives `mem_be` = 4'b1111 with `mem_wdata` = `st_data`.
- R5: A store is misaligned when it is a halfword at an odd offset, a word at a nonzero offset, or uses the reserved size code 2'b11. A misaligned store sets `st_misalign` and drives `mem_be` and `mem_wdata` to zero.
- R6: A cycle with `st_req` low gives `mem_be` = 0, `mem_wdata` = 0 and `st_misalign` = 0 on the next edge.
- R7: A byte load takes bits 8k+7..8k of `ld_rword` for offset k. With `ld_unsigned` = 0 it copies bit 7 into the upper bits; with `ld_unsigned` = 1 it fills them with zero. For example, byte 0x80 gives 0xffffff80 or 0x00000080.
- R8: A halfword load at even offset k takes bytes k and k+1, with byte k as the low byte. It is sign-extended from bit 15 when `ld_unsigned` = 0 and zero-extended otherwise. For example, bytes b7 then 87 give 0xffff87b7 or 0x000087b7.
- R9: A word load at offset 0 returns `ld_rword` whole. For example, bytes 03 a5 07 43 from the lowest address give 0x4307a503.
- R10: A load that breaks the R5 alignment rules sets `ld_misalign` and returns `ld_result` = 0.
- R11: `ld_valid` follows `ld_req` by one cycle. When `ld_req` is low, `ld_result` and `ld_misalign` are zero. A store and a load presented in the same cycle both complete on the next edge without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_req | input | 1 | Store request this cycle |
| st_size | input | 2 | Store size: 00 byte, 01 half, 10 word, 11 reserved |
| st_off | input | 2 | Low address bits of the store |
| st_data | input | 32 | Store source register value |
| mem_be | output | 4 | Registered byte write enables |
| mem_wdata | output | 32 | Registered lane-steered write data |
| st_misalign | output | 1 | Registered store misalignment flag |
| ld_req | input | 1 | Load request this cycle |
| ld_size | input | 2 | Load size, same code as st_size |
| ld_unsigned | input | 1 | 1 selects zero extension, 0 sign extension |
| ld_off | input | 2 | Low address bits of the load |
| ld_rword | input | 32 | Word read from memory |
| ld_valid | output | 1 | Registered load result valid |
| ld_result | output | 32 | Registered extended load value |
| ld_misalign | output | 1 | Registered load misalignment flag |

## Verification
Store steering and load extraction can both be requested in the same cycle. The bench drives both on every step of its sweep: the same size and offset, a different data word on each side, and every combination of size code, offset, signedness and four data patterns. Each side is compared on the next edge against values computed with shifts and masks in the bench. A store-only error that disturbs the load, or the reverse, shows up as a mismatch on the other path. A small inline word memory then merges the enabled lanes of real stores and reads the results back through loads. This confirms that the bytes outside the enables stay unchanged.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_t;
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_lane_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB)
) (
  input  acc_size_t       size,
  input  logic [OW-1:0]   off,
  output logic            misalign
);
  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = off[0];
      SZ_WORD: misalign = (off != '0);
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic            req,
  input  logic            misalign,
  input  acc_size_t       size,
  input  logic [OW-1:0]   off,
  input  logic [XLEN-1:0] data,
  output logic [NB-1:0]   be,
  output logic [XLEN-1:0] lanes
);
  logic allow;
  assign allow = req && !misalign;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam logic [OW-1:0] LANE = OW'(k);
    int unsigned src;
    logic        hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: begin hit = (off == LANE);               src = 0;     end
        SZ_HALF: begin hit = (off[OW-1:1] == LANE[OW-1:1]); src = k % 2; end
        SZ_WORD: begin hit = 1'b1;                         src = k;     end
        default: begin hit = 1'b0;                         src = 0;     end
      endcase
    end
    assign be[k] = allow && hit;
    assign lanes[8*k +: 8] = be[k] ? data[8*src +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic            misalign,
  input  acc_size_t       size,
  input  logic            zext,
  input  logic [OW-1:0]   off,
  input  logic [XLEN-1:0] rword,
  output logic [XLEN-1:0] value
);
  logic [XLEN-1:0] shifted;
  logic            fill_b;
  logic            fill_h;

  assign shifted = rword >> (8 * off);
  assign fill_b  = !zext && shifted[7];
  assign fill_h  = !zext && shifted[15];

  always_comb begin
    if (misalign) begin
      value = '0;
    end else begin
      unique case (size)
        SZ_BYTE: value = {{(XLEN-8){fill_b}}, shifted[7:0]};
        SZ_HALF: value = {{(XLEN-16){fill_h}}, shifted[15:0]};
        SZ_WORD: value = rword;
        default: value = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
  import lsu_lane_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_req,
  input  logic [1:0]      st_size,
  input  logic [OW-1:0]   st_off,
  input  logic [XLEN-1:0] st_data,
  output logic [NB-1:0]   mem_be,
  output logic [XLEN-1:0] mem_wdata,
  output logic            st_misalign,
  input  logic            ld_req,
  input  logic [1:0]      ld_size,
  input  logic            ld_unsigned,
  input  logic [OW-1:0]   ld_off,
  input  logic [XLEN-1:0] ld_rword,
  output logic            ld_valid,
  output logic [XLEN-1:0] ld_result,
  output logic            ld_misalign
);
  acc_size_t       st_sz, ld_sz;
  logic            st_mis_c, ld_mis_c;
  logic [NB-1:0]   be_c;
  logic [XLEN-1:0] lanes_c, value_c;

  assign st_sz = acc_size_t'(st_size);
  assign ld_sz = acc_size_t'(ld_size);

  lsu_align_check #(.XLEN(XLEN)) u_st_align (.size(st_sz), .off(st_off), .misalign(st_mis_c));
  lsu_align_check #(.XLEN(XLEN)) u_ld_align (.size(ld_sz), .off(ld_off), .misalign(ld_mis_c));

  lsu_store_steer #(.XLEN(XLEN)) u_steer (
    .req(st_req), .misalign(st_mis_c), .size(st_sz), .off(st_off),
    .data(st_data), .be(be_c), .lanes(lanes_c)
  );

  lsu_load_extract #(.XLEN(XLEN)) u_extract (
    .misalign(ld_mis_c), .size(ld_sz), .zext(ld_unsigned), .off(ld_off),
    .rword(ld_rword), .value(value_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_be      <= '0;
      mem_wdata   <= '0;
      st_misalign <= 1'b0;
      ld_valid    <= 1'b0;
      ld_result   <= '0;
      ld_misalign <= 1'b0;
    end else begin
      mem_be      <= be_c;
      mem_wdata   <= lanes_c;
      st_misalign <= st_req && st_mis_c;
      ld_valid    <= ld_req;
      ld_result   <= ld_req ? value_c : '0;
      ld_misalign <= ld_req && ld_mis_c;
    end
  end

  // R2: a byte store enables exactly one lane
  a_r2_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_size == 2'b00) |=> ($countones(mem_be) == 1));

  // R4: an aligned word store enables every lane
  a_r4_word_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_size == 2'b10 && st_off == '0) |=> (mem_be == '1));

  // R5: a flagged store never writes
  a_r5_misalign_no_write: assert property (@(posedge clk) disable iff (rst)
    st_misalign |-> (mem_be == '0 && mem_wdata == '0));

  // R6: idle store side stays quiet
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !st_req |=> (mem_be == '0 && !st_misalign));

  // R7: signed byte load upper bits are a pure copy of the sign
  a_r7_byte_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_size == 2'b00 && !ld_unsigned) |=>
    (ld_result[XLEN-1:8] == '0 || ld_result[XLEN-1:8] == '1));

  // R8: unsigned halfword load has a clear upper part
  a_r8_half_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_size == 2'b01 && ld_unsigned) |=> (ld_result[XLEN-1:16] == '0));

  // R10: a flagged load returns zero
  a_r10_misalign_zero: assert property (@(posedge clk) disable iff (rst)
    ld_misalign |-> (ld_result == '0 && ld_valid));

  // R11: valid tracks the request one cycle later
  a_r11_valid_latency: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> ld_valid);
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !ld_req |=> (!ld_valid && ld_result == '0));
endmodule

// File: tb/lsu_byte_lane_tb_top.sv
module lsu_byte_lane_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_req = 1'b0;
  logic [1:0]  st_size = 2'b00;
  logic [1:0]  st_off = 2'b00;
  logic [31:0] st_data = '0;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        st_misalign;
  logic        ld_req = 1'b0;
  logic [1:0]  ld_size = 2'b00;
  logic        ld_unsigned = 1'b0;
  logic [1:0]  ld_off = 2'b00;
  logic [31:0] ld_rword = '0;
  logic        ld_valid;
  logic [31:0] ld_result;
  logic        ld_misalign;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] mem_word;

  always #10 clk = ~clk;

  lsu_byte_lane dut_i (
    .clk(clk), .rst(rst),
    .st_req(st_req), .st_size(st_size), .st_off(st_off), .st_data(st_data),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .st_misalign(st_misalign),
    .ld_req(ld_req), .ld_size(ld_size), .ld_unsigned(ld_unsigned),
    .ld_off(ld_off), .ld_rword(ld_rword),
    .ld_valid(ld_valid), .ld_result(ld_result), .ld_misalign(ld_misalign)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_mis(input int sz, input int off);
    if (sz == 0) return 0;
    if (sz == 1) return off[0];
    if (sz == 2) return off != 0;
    return 1;
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input int off);
    if (exp_mis(sz, off)) return 4'h0;
    if (sz == 0) return 4'(1 << off);
    if (sz == 1) return 4'(3 << off);
    return 4'hf;
  endfunction

  function automatic logic [31:0] exp_wd(input int sz, input int off, input logic [31:0] d);
    if (exp_mis(sz, off)) return 32'h0;
    if (sz == 0) return (d & 32'hff) << (8 * off);
    if (sz == 1) return (d & 32'hffff) << (8 * off);
    return d;
  endfunction

  function automatic logic [31:0] exp_ld(input int sz, input int off, input bit u,
                                         input logic [31:0] w);
    logic [31:0] s;
    s = w >> (8 * off);
    if (exp_mis(sz, off)) return 32'h0;
    if (sz == 0) return (!u && s[7]) ? (s | 32'hffffff00) : (s & 32'hff);
    if (sz == 1) return (!u && s[15]) ? (s | 32'hffff0000) : (s & 32'hffff);
    return w;
  endfunction

  function automatic string size_tag(input int sz, input bit mis, input bit ld);
    if (mis) return ld ? "R10" : "R5";
    if (sz == 0) return ld ? "R7" : "R2";
    if (sz == 1) return ld ? "R8" : "R3";
    return ld ? "R9" : "R4";
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Store into the inline memory word and merge the enabled lanes
  task automatic mem_store(input int sz, input int off, input logic [31:0] d);
    @(negedge clk);
    st_req = 1; st_size = 2'(sz); st_off = 2'(off); st_data = d;
    @(negedge clk);
    st_req = 0;
    for (int k = 0; k < 4; k++)
      if (mem_be[k]) mem_word[8*k +: 8] = mem_wdata[8*k +: 8];
  endtask

  task automatic mem_load(input int sz, input int off, input bit u, input string tag,
                          input logic [31:0] exp);
    @(negedge clk);
    ld_req = 1; ld_size = 2'(sz); ld_off = 2'(off); ld_unsigned = u; ld_rword = mem_word;
    @(negedge clk);
    ld_req = 0;
    check(tag, "memory load", ld_result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h12345678; pats[1] = 32'h87654321;
    pats[2] = 32'h4307a503; pats[3] = 32'hffff80b7;

    // R1: reset state, inputs active during reset
    @(negedge clk);
    st_req = 1; st_size = 2'b10; st_data = 32'hdeadbeef; ld_req = 1; ld_rword = 32'h1;
    @(negedge clk); @(negedge clk);
    check("R1", "mem_be", {28'h0, mem_be}, 32'h0);
    check("R1", "mem_wdata", mem_wdata, 32'h0);
    check("R1", "flags/valid", {29'h0, st_misalign, ld_misalign, ld_valid}, 32'h0);
    check("R1", "ld_result", ld_result, 32'h0);
    st_req = 0; ld_req = 0;
    rst = 0;

    // R6 and R11: idle sides
    @(negedge clk);
    check("R6", "idle mem_be", {28'h0, mem_be}, 32'h0);
    check("R6", "idle st_misalign", {31'h0, st_misalign}, 32'h0);
    check("R11", "idle ld_valid", {31'h0, ld_valid}, 32'h0);

    // Sweep: store and load in the same cycle, every size/offset/signedness
    for (int p = 0; p < 4; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int off = 0; off < 4; off++) begin
          for (int u = 0; u < 2; u++) begin
            bit m;
            m = exp_mis(sz, off);
            st_req = 1; st_size = 2'(sz); st_off = 2'(off); st_data = pats[p];
            ld_req = 1; ld_size = 2'(sz); ld_off = 2'(off); ld_unsigned = u[0];
            ld_rword = ~pats[3 - p];
            @(negedge clk);
            check(size_tag(sz, m, 0), "mem_be", {28'h0, mem_be}, {28'h0, exp_be(sz, off)});
            check(size_tag(sz, m, 0), "mem_wdata", mem_wdata, exp_wd(sz, off, pats[p]));
            check("R5", "st_misalign", {31'h0, st_misalign}, {31'h0, m});
            check(size_tag(sz, m, 1), "ld_result", ld_result,
                  exp_ld(sz, off, u[0], ~pats[3 - p]));
            check("R10", "ld_misalign", {31'h0, ld_misalign}, {31'h0, m});
            check("R11", "ld_valid", {31'h0, ld_valid}, 32'h1);
          end
        end
      end
    end

    // R11: load alone, store side idle, then store alone
    st_req = 0; ld_req = 1; ld_size = 2'b10; ld_off = 0; ld_rword = 32'ha5a5a5a5;
    @(negedge clk);
    check("R11", "load alone", ld_result, 32'ha5a5a5a5);
    check("R6", "store idle during load", {28'h0, mem_be} | mem_wdata, 32'h0);
    ld_req = 0; st_req = 1; st_size = 2'b00; st_off = 2'd3; st_data = 32'h000000c3;
    @(negedge clk);
    check("R11", "load idle result", ld_result, 32'h0);
    check("R11", "load idle valid", {31'h0, ld_valid}, 32'h0);
    check("R2", "byte lane 3", mem_wdata, 32'hc3000000);
    st_req = 0;

    // Inline memory model: bytes 67 80 00 00 from the lowest address
    mem_word = 32'h00008067;
    mem_load(0, 1, 0, "R7", 32'hffffff80);
    mem_load(0, 1, 1, "R7", 32'h00000080);
    mem_store(0, 1, 32'h12345678);
    check("R2", "byte merge", mem_word, 32'h00007867);
    mem_word = 32'h00008067;
    mem_store(1, 2, 32'h12345678);
    check("R3", "half merge", mem_word, 32'h56788067);
    mem_store(2, 0, 32'h12345678);
    check("R4", "word merge", mem_word, 32'h12345678);
    mem_store(1, 3, 32'hffffffff);
    check("R5", "misaligned store leaves memory", mem_word, 32'h12345678);
    mem_word = 32'h000087b7;
    mem_load(1, 0, 0, "R8", 32'hffff87b7);
    mem_load(1, 0, 1, "R8", 32'h000087b7);
    mem_word = 32'h4307a503;
    mem_load(2, 0, 0, "R9", 32'h4307a503);
    mem_load(2, 2, 0, "R10", 32'h0);

    done = 1;
    summary();
  end
endmodule